// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the eight 16-bit control registers of a small CPU. An instruction names a register with a 3-bit index. A read port returns data combinationally in the same cycle. A write port commits at the next rising clock edge. A force-zero input redirects any access to index 0. Each index has its own access type: read-write, read-only or write-only. Only index 0, the ALU flag word, may be touched while the CPU runs in user mode.

Some registers also have side paths fed by hardware:
- The ALU can update the flags directly.
- Interrupt entry and the syscall instruction load the cause register.
- A page fault loads the MMU virtual page register.

Writing index 7 stores nothing. It fires a strobe that carries the written word to the MMU table, at the page address held in index 6. Each register's contents are also driven on dedicated outputs for the rest of the core.

Top module: `ctrl_reg_bank`

## Requirements
- R1: A synchronous active-low reset clears every register except the kernel bit of the CPU status word. After reset, index 1 reads 0x0002 and all other registers read 0.
- R2: Index 0 holds the ALU flags in bits [3:0] (bit0 carry, bit1 zero, bit2 negative, bit3 overflow). It is read-write and reachable in user mode. When flag_upd is high, flag_in loads the flags. A software write to index 0 in the same cycle takes priority over flag_upd.
- R3: Index 1 holds the CPU status in bits [3:0] (bit0 interrupt enable, bit1 kernel, bit2 MMU enable, bit3 sleep). It is read-write, and its upper bits always read 0.
- R4: Index 2 (6-bit context ID, bits [5:0]) and index 4 (16-bit interrupt vector base) are write-only. Reading them returns 0. Their stored values appear on ctx_id and int_base.
- R5: Index 3, the interrupt cause, is read-only. A write to it leaves the cause unchanged.
- R6: Index 5, the saved PC, is read-write and its value appears on saved_pc.
- R7: Index 6, the MMU page address, is read-write. When pf_take is high, pf_vpage loads it. A page fault wins over a software write in the same cycle.
- R8: A kernel write to index 7 raises mmu_wr_stb in that same cycle. mmu_wr_data equals wr_data and mmu_wr_addr equals the current index-6 value. Reading index 7 returns 0.
- R9: irq_take loads the cause with {8'h00, irq_id} at the next edge, and raises irq_pend_clr in the same cycle.
- R10: sys_take loads cause bits [15:8] with {2'b00, sys_imm} and keeps bits [7:0]. If irq_take and sys_take occur together, the result is {2'b00, sys_imm, irq_id}.
- R11: When force_zero is high, the access goes to index 0 whatever sel_idx holds.
- R12: In user mode (priv_kernel low), a read or write to any index other than 0 has no effect: reads return 0, writes change nothing and produce no MMU strobe. The access also raises priv_fault for exactly one cycle, starting at the next edge.
- R13: rd_data is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_idx | input | 3 | Register index from the instruction |
| force_zero | input | 1 | Redirect the access to index 0 |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | 16 | Write data |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| flag_upd | input | 1 | ALU flag update strobe |
| flag_in | input | 4 | New ALU flags |
| irq_take | input | 1 | Interrupt entry strobe |
| irq_id | input | 8 | Interrupt identifier |
| sys_take | input | 1 | Syscall strobe |
| sys_imm | input | 6 | Syscall immediate |
| pf_take | input | 1 | Page fault strobe |
| pf_vpage | input | 16 | Faulting virtual page address |
| rd_data | output | 16 | Read data (combinational) |
| priv_fault | output | 1 | One-cycle privilege violation pulse |
| mmu_wr_stb | output | 1 | MMU table write strobe |
| mmu_wr_addr | output | 16 | MMU table write address (index 6) |
| mmu_wr_data | output | 16 | MMU table write record |
| irq_pend_clr | output | 1 | Clear the pending interrupt |
| alu_flags | output | 4 | Current ALU flags |
| cpu_stat | output | 4 | Current CPU status bits |
| ctx_id | output | 6 | Current context ID |
| int_base | output | 16 | Interrupt vector base |
| saved_pc | output | 16 | Saved PC / return target |

## Verification
The side-path properties assume the strobes are single-cycle events. They also assume irq_id fits the low byte, and that flag_upd and pf_take may coincide with software writes but never arrive during reset. The fault properties assume priv_kernel is stable across each access cycle. The bench changes every input only on the falling edge and raises each strobe for exactly one cycle. It deliberately overlaps the side paths with software writes so that every priority rule is exercised.

// File: rtl/ctrl_reg_pkg.sv
// Package: register indices, access classes and bit positions shared by
// the control register bank. Assumes a fixed eight-entry index space.
package ctrl_reg_pkg;
    localparam int NREG  = 8;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_FLAGS = 3'd0,
        IDX_STAT  = 3'd1,
        IDX_CTX   = 3'd2,
        IDX_CAUSE = 3'd3,
        IDX_VBASE = 3'd4,
        IDX_EPC   = 3'd5,
        IDX_VPAGE = 3'd6,
        IDX_MDATA = 3'd7
    } creg_idx_e;

    typedef enum logic [1:0] {
        ACC_RW = 2'd0,
        ACC_RO = 2'd1,
        ACC_WO = 2'd2
    } acc_e;

    // Access class of each index.
    function automatic acc_e acc_of(logic [IDX_W-1:0] idx);
        case (idx)
            IDX_CTX, IDX_VBASE, IDX_MDATA: return ACC_WO;
            IDX_CAUSE:                     return ACC_RO;
            default:                       return ACC_RW;
        endcase
    endfunction

    localparam int STAT_KERNEL = 1;
endpackage

// File: rtl/ctrl_access_dec.sv
// Access decoder: resolves the effective index, applies the privilege and
// access-type rules and produces one-hot write enables plus the registered
// privilege-fault pulse. Assumes priv_kernel is stable within a cycle.
module ctrl_access_dec
    import ctrl_reg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      sel_idx,
    input  logic                  force_zero,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic                  priv_kernel,
    output logic [IDX_W-1:0]      eff_idx,
    output logic                  rd_ok,
    output logic [NREG-1:0]       wr_sel,
    output logic                  priv_fault
);
    logic allowed;
    logic violation;

    // Effective index and privilege gate.
    always_comb begin
        eff_idx   = force_zero ? IDX_W'(IDX_FLAGS) : sel_idx;
        allowed   = priv_kernel || (eff_idx == IDX_FLAGS);
        violation = (rd_en || wr_en) && !allowed;
        rd_ok     = rd_en && allowed && (acc_of(eff_idx) != ACC_WO);
    end

    // One write enable per index; read-only entries never get one.
    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        if (acc_of(GI) == ACC_RO) begin : g_ro
            assign wr_sel[g] = 1'b0;
        end else begin : g_wr
            assign wr_sel[g] = wr_en && allowed && (eff_idx == GI);
        end
    end

    // Registered one-cycle fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_fault <= 1'b0;
        else        priv_fault <= violation;
    end

    // R12: a user access outside index 0 flags a fault on the next cycle
    a_r12_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !priv_kernel && (eff_idx != IDX_FLAGS)) |=> priv_fault);
    // R12: the fault lasts one cycle unless a new violation occurs
    a_r12_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_fault && !((rd_en || wr_en) && !priv_kernel && (eff_idx != IDX_FLAGS)))
        |=> !priv_fault);
    // R11: force_zero only ever allows a write to index 0
    a_r11_force_target: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |-> (wr_sel[NREG-1:1] == '0));
    // R8: at most one register is written in a cycle
    a_r8_onehot_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/ctrl_reg_store.sv
// Register storage: holds the flag, status, context, cause, vector base,
// saved PC and page-address registers, merging software writes with the
// hardware side paths. Assumes IRQ_ID_W and SYS_W fit in half a word.
module ctrl_reg_store
    import ctrl_reg_pkg::*;
#(
    parameter int DW       = 16,
    parameter int FLAG_W   = 4,
    parameter int STAT_W   = 4,
    parameter int CTX_W    = 6,
    parameter int IRQ_ID_W = 8,
    parameter int SYS_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREG-1:0]     wr_sel,
    input  logic [DW-1:0]       wr_data,
    input  logic                flag_upd,
    input  logic [FLAG_W-1:0]   flag_in,
    input  logic                irq_take,
    input  logic [IRQ_ID_W-1:0] irq_id,
    input  logic                sys_take,
    input  logic [SYS_W-1:0]    sys_imm,
    input  logic                pf_take,
    input  logic [DW-1:0]       pf_vpage,
    output logic [FLAG_W-1:0]   flags_q,
    output logic [STAT_W-1:0]   stat_q,
    output logic [CTX_W-1:0]    ctx_q,
    output logic [DW-1:0]       cause_q,
    output logic [DW-1:0]       vbase_q,
    output logic [DW-1:0]       epc_q,
    output logic [DW-1:0]       vpage_q
);
    localparam int HALF = DW / 2;
    localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << STAT_KERNEL;

    logic [DW-1:0] cause_d;

    // Next cause value from interrupt entry and syscall paths.
    always_comb begin
        cause_d = cause_q;
        if (irq_take) cause_d = {{(DW-IRQ_ID_W){1'b0}}, irq_id};
        if (sys_take) cause_d[DW-1:HALF] = {{(HALF-SYS_W){1'b0}}, sys_imm};
    end

    // Register update with software/hardware priorities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            stat_q  <= STAT_RST;
            ctx_q   <= '0;
            cause_q <= '0;
            vbase_q <= '0;
            epc_q   <= '0;
            vpage_q <= '0;
        end else begin
            if (wr_sel[IDX_FLAGS])  flags_q <= wr_data[FLAG_W-1:0];
            else if (flag_upd)      flags_q <= flag_in;
            if (wr_sel[IDX_STAT])   stat_q  <= wr_data[STAT_W-1:0];
            if (wr_sel[IDX_CTX])    ctx_q   <= wr_data[CTX_W-1:0];
            if (wr_sel[IDX_VBASE])  vbase_q <= wr_data;
            if (wr_sel[IDX_EPC])    epc_q   <= wr_data;
            if (pf_take)            vpage_q <= pf_vpage;
            else if (wr_sel[IDX_VPAGE]) vpage_q <= wr_data;
            cause_q <= cause_d;
        end
    end

    // R1: reset leaves only the kernel bit set
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (stat_q == STAT_RST && flags_q == '0 && cause_q == '0 && epc_q == '0));
    // R9: interrupt entry loads the id in the low part and clears the rest
    a_r9_cause_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !sys_take) |=> (cause_q == {{(DW-IRQ_ID_W){1'b0}}, $past(irq_id)}));
    // R10: syscall loads the upper half
    a_r10_cause_sys: assert property (@(posedge clk) disable iff (!rst_n)
        sys_take |=> (cause_q[DW-1:HALF] == {{(HALF-SYS_W){1'b0}}, $past(sys_imm)}));
    // R7: page fault wins over a software write
    a_r7_pf_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pf_take |=> (vpage_q == $past(pf_vpage)));
    // R2: ALU update applies when software leaves the flags alone
    a_r2_flag_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && !wr_sel[IDX_FLAGS]) |=> (flags_q == $past(flag_in)));
endmodule

// File: rtl/ctrl_read_mux.sv
// Read multiplexer: selects the addressed register onto the read bus,
// zero-extending narrow registers; returns zero when the read is refused.
module ctrl_read_mux
    import ctrl_reg_pkg::*;
#(
    parameter int DW     = 16,
    parameter int FLAG_W = 4,
    parameter int STAT_W = 4
) (
    input  logic [IDX_W-1:0]  eff_idx,
    input  logic              rd_ok,
    input  logic [FLAG_W-1:0] flags_q,
    input  logic [STAT_W-1:0] stat_q,
    input  logic [DW-1:0]     cause_q,
    input  logic [DW-1:0]     epc_q,
    input  logic [DW-1:0]     vpage_q,
    output logic [DW-1:0]     rd_data
);
    // Read data selection; write-only entries fall to zero.
    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            case (eff_idx)
                IDX_FLAGS: rd_data = DW'(flags_q);
                IDX_STAT:  rd_data = DW'(stat_q);
                IDX_CAUSE: rd_data = cause_q;
                IDX_EPC:   rd_data = epc_q;
                IDX_VPAGE: rd_data = vpage_q;
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ctrl_reg_bank.sv
// Top: privileged control register bank. Combines the access decoder,
// register storage and read mux, and drives the MMU write strobe.
// Assumes side-path strobes are single-cycle events.
module ctrl_reg_bank
    import ctrl_reg_pkg::*;
#(
    parameter int DW       = 16,
    parameter int FLAG_W   = 4,
    parameter int STAT_W   = 4,
    parameter int CTX_W    = 6,
    parameter int IRQ_ID_W = 8,
    parameter int SYS_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          sel_idx,
    input  logic                force_zero,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                priv_kernel,
    input  logic                flag_upd,
    input  logic [FLAG_W-1:0]   flag_in,
    input  logic                irq_take,
    input  logic [IRQ_ID_W-1:0] irq_id,
    input  logic                sys_take,
    input  logic [SYS_W-1:0]    sys_imm,
    input  logic                pf_take,
    input  logic [DW-1:0]       pf_vpage,
    output logic [DW-1:0]       rd_data,
    output logic                priv_fault,
    output logic                mmu_wr_stb,
    output logic [DW-1:0]       mmu_wr_addr,
    output logic [DW-1:0]       mmu_wr_data,
    output logic                irq_pend_clr,
    output logic [FLAG_W-1:0]   alu_flags,
    output logic [STAT_W-1:0]   cpu_stat,
    output logic [CTX_W-1:0]    ctx_id,
    output logic [DW-1:0]       int_base,
    output logic [DW-1:0]       saved_pc
);
    logic [IDX_W-1:0] eff_idx;
    logic             rd_ok;
    logic [NREG-1:0]  wr_sel;
    logic [DW-1:0]    cause_q;
    logic [DW-1:0]    vpage_q;

    ctrl_access_dec u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_idx     (sel_idx),
        .force_zero  (force_zero),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .priv_kernel (priv_kernel),
        .eff_idx     (eff_idx),
        .rd_ok       (rd_ok),
        .wr_sel      (wr_sel),
        .priv_fault  (priv_fault)
    );

    ctrl_reg_store #(
        .DW(DW), .FLAG_W(FLAG_W), .STAT_W(STAT_W),
        .CTX_W(CTX_W), .IRQ_ID_W(IRQ_ID_W), .SYS_W(SYS_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .flag_upd (flag_upd),
        .flag_in  (flag_in),
        .irq_take (irq_take),
        .irq_id   (irq_id),
        .sys_take (sys_take),
        .sys_imm  (sys_imm),
        .pf_take  (pf_take),
        .pf_vpage (pf_vpage),
        .flags_q  (alu_flags),
        .stat_q   (cpu_stat),
        .ctx_q    (ctx_id),
        .cause_q  (cause_q),
        .vbase_q  (int_base),
        .epc_q    (saved_pc),
        .vpage_q  (vpage_q)
    );

    ctrl_read_mux #(.DW(DW), .FLAG_W(FLAG_W), .STAT_W(STAT_W)) u_rmux (
        .eff_idx (eff_idx),
        .rd_ok   (rd_ok),
        .flags_q (alu_flags),
        .stat_q  (cpu_stat),
        .cause_q (cause_q),
        .epc_q   (saved_pc),
        .vpage_q (vpage_q),
        .rd_data (rd_data)
    );

    // MMU record write: index 7 forwards data at the staged page address.
    always_comb begin
        mmu_wr_stb   = wr_sel[IDX_MDATA];
        mmu_wr_data  = wr_data;
        mmu_wr_addr  = vpage_q;
        irq_pend_clr = irq_take;
    end

    // R12: no MMU strobe is possible in user mode
    a_r12_user_no_mmu: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_kernel |-> !mmu_wr_stb);
    // R12: a user write to the saved PC leaves it untouched
    a_r12_user_epc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !priv_kernel && !force_zero && sel_idx == 3'd5) |=> $stable(saved_pc));
    // R13: an idle read port yields zero
    a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
    // R5: a write to the cause register never changes it without a side path
    a_r5_cause_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !irq_take && !sys_take) |=> $stable(cause_q));
endmodule

// File: tb/ctrl_reg_bank_tb.sv
module ctrl_reg_bank_tb;
    localparam int CLK_P = 10;
    localparam int NV    = 15;
    // {wr, rd, kernel, idx[2:0], data[15:0], expected read[15:0]}
    localparam logic [37:0] VEC [NV] = '{
        {1'b1,1'b0,1'b1,3'd0,16'hFFFF,16'h0000},
        {1'b0,1'b1,1'b1,3'd0,16'h0000,16'h000F},
        {1'b1,1'b0,1'b1,3'd1,16'h00FF,16'h0000},
        {1'b0,1'b1,1'b1,3'd1,16'h0000,16'h000F},
        {1'b1,1'b0,1'b1,3'd5,16'hBEEF,16'h0000},
        {1'b0,1'b1,1'b1,3'd5,16'h0000,16'hBEEF},
        {1'b1,1'b0,1'b1,3'd6,16'h1234,16'h0000},
        {1'b0,1'b1,1'b1,3'd6,16'h0000,16'h1234},
        {1'b1,1'b0,1'b1,3'd2,16'hFFFF,16'h0000},
        {1'b0,1'b1,1'b1,3'd2,16'h0000,16'h0000},
        {1'b1,1'b0,1'b1,3'd3,16'hABCD,16'h0000},
        {1'b0,1'b1,1'b1,3'd3,16'h0000,16'h0000},
        {1'b0,1'b1,1'b0,3'd0,16'h0000,16'h000F},
        {1'b1,1'b0,1'b0,3'd0,16'h0005,16'h0000},
        {1'b0,1'b1,1'b0,3'd0,16'h0000,16'h0005}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] sel_idx = '0;
    logic force_zero = 1'b0, rd_en = 1'b0, wr_en = 1'b0, priv_kernel = 1'b1;
    logic [15:0] wr_data = '0, pf_vpage = '0;
    logic flag_upd = 1'b0, irq_take = 1'b0, sys_take = 1'b0, pf_take = 1'b0;
    logic [3:0] flag_in = '0;
    logic [7:0] irq_id = '0;
    logic [5:0] sys_imm = '0;
    logic [15:0] rd_data, mmu_wr_addr, mmu_wr_data, int_base, saved_pc;
    logic priv_fault, mmu_wr_stb, irq_pend_clr;
    logic [3:0] alu_flags, cpu_stat;
    logic [5:0] ctx_id;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ctrl_reg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .force_zero(force_zero),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .priv_kernel(priv_kernel),
        .flag_upd(flag_upd), .flag_in(flag_in), .irq_take(irq_take), .irq_id(irq_id),
        .sys_take(sys_take), .sys_imm(sys_imm), .pf_take(pf_take), .pf_vpage(pf_vpage),
        .rd_data(rd_data), .priv_fault(priv_fault), .mmu_wr_stb(mmu_wr_stb),
        .mmu_wr_addr(mmu_wr_addr), .mmu_wr_data(mmu_wr_data), .irq_pend_clr(irq_pend_clr),
        .alu_flags(alu_flags), .cpu_stat(cpu_stat), .ctx_id(ctx_id),
        .int_base(int_base), .saved_pc(saved_pc)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; force_zero = 0; flag_upd = 0;
        irq_take = 0; sys_take = 0; pf_take = 0; priv_kernel = 1;
    endtask

    // Kernel read at the current negedge, then back to idle.
    task automatic rd_chk(input string tag, input logic [2:0] idx, input logic [15:0] exp);
        @(negedge clk); idle(); rd_en = 1; sel_idx = idx; #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wr_do(input logic k, input logic [2:0] idx, input logic [15:0] d);
        @(negedge clk); idle(); priv_kernel = k; wr_en = 1; sel_idx = idx; wr_data = d;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        check("R1 cpu_stat", 16'(cpu_stat), 16'h0002);
        check("R1 flags", 16'(alu_flags), 16'h0000);
        rd_chk("R1 read idx1", 3'd1, 16'h0002);
        rd_chk("R1 read idx5", 3'd5, 16'h0000);

        // Vector table: R2 R3 R4 R5 R6 R7 basic access
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); idle();
            wr_en = VEC[i][37]; rd_en = VEC[i][36]; priv_kernel = VEC[i][35];
            sel_idx = VEC[i][34:32]; wr_data = VEC[i][31:16];
            #1;
            if (VEC[i][36]) check($sformatf("R2-R7 vector %0d", i), rd_data, VEC[i][15:0]);
        end
        @(negedge clk); idle(); #1;
        check("R4 ctx_id port", 16'(ctx_id), 16'h003F);
        check("R6 saved_pc port", saved_pc, 16'hBEEF);

        // R4: vector base write-only
        wr_do(1, 3'd4, 16'h8000);
        rd_chk("R4 read idx4", 3'd4, 16'h0000);
        check("R4 int_base port", int_base, 16'h8000);

        // R8: MMU strobe
        @(negedge clk); idle(); wr_en = 1; sel_idx = 3'd7; wr_data = 16'h5A5A; #1;
        check("R8 stb", 16'(mmu_wr_stb), 16'h0001);
        check("R8 data", mmu_wr_data, 16'h5A5A);
        check("R8 addr", mmu_wr_addr, 16'h1234);
        rd_chk("R8 read idx7", 3'd7, 16'h0000);
        @(negedge clk); idle(); priv_kernel = 0; wr_en = 1; sel_idx = 3'd7; #1;
        check("R12 user no stb", 16'(mmu_wr_stb), 16'h0000);

        // R2: flag update path and priority
        @(negedge clk); idle(); flag_upd = 1; flag_in = 4'hA;
        rd_chk("R2 alu update", 3'd0, 16'h000A);
        @(negedge clk); idle(); wr_en = 1; sel_idx = 3'd0; wr_data = 16'h0003;
        flag_upd = 1; flag_in = 4'hC;
        rd_chk("R2 sw wins", 3'd0, 16'h0003);

        // R9 R10: cause side paths
        @(negedge clk); idle(); irq_take = 1; irq_id = 8'h42; #1;
        check("R9 pend clr", 16'(irq_pend_clr), 16'h0001);
        rd_chk("R9 cause irq", 3'd3, 16'h0042);
        @(negedge clk); idle(); sys_take = 1; sys_imm = 6'h3F;
        rd_chk("R10 cause sys", 3'd3, 16'h3F42);
        @(negedge clk); idle(); irq_take = 1; irq_id = 8'h07; sys_take = 1; sys_imm = 6'h01;
        rd_chk("R10 both", 3'd3, 16'h0107);
        @(negedge clk); idle(); irq_take = 1; irq_id = 8'h09;
        rd_chk("R9 upper cleared", 3'd3, 16'h0009);
        wr_do(1, 3'd3, 16'hFFFF);
        rd_chk("R5 cause kept", 3'd3, 16'h0009);

        // R7: page fault priority
        @(negedge clk); idle(); pf_take = 1; pf_vpage = 16'h7777;
        wr_en = 1; sel_idx = 3'd6; wr_data = 16'h1111;
        rd_chk("R7 pf wins", 3'd6, 16'h7777);

        // R11: force_zero
        @(negedge clk); idle(); rd_en = 1; sel_idx = 3'd5; force_zero = 1; #1;
        check("R11 read forced", rd_data, 16'h0003);
        @(negedge clk); idle(); wr_en = 1; sel_idx = 3'd5; force_zero = 1; wr_data = 16'h0006;
        @(negedge clk); idle(); #1;
        check("R11 flags written", 16'(alu_flags), 16'h0006);
        check("R11 pc untouched", saved_pc, 16'hBEEF);

        // R12: user-mode violation
        wr_do(0, 3'd5, 16'h0000);
        @(negedge clk); idle(); #1;
        check("R12 fault pulse", 16'(priv_fault), 16'h0001);
        check("R12 pc kept", saved_pc, 16'hBEEF);
        @(negedge clk); #1;
        check("R12 fault ends", 16'(priv_fault), 16'h0000);
        @(negedge clk); idle(); priv_kernel = 0; rd_en = 1; sel_idx = 3'd1; #1;
        check("R12 user read zero", rd_data, 16'h0000);

        // R13: idle read port
        @(negedge clk); idle(); sel_idx = 3'd5; #1;
        check("R13 idle zero", rd_data, 16'h0000);

        // R1: mid-run reset
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        check("R1 rerst stat", 16'(cpu_stat), 16'h0002);
        check("R1 rerst pc", saved_pc, 16'h0000);
        check("R1 rerst base", int_base, 16'h0000);
        check("R1 rerst ctx", 16'(ctx_id), 16'h0000);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule